// File: doc/BRIEF.md
# Dual-Lane Halfword Multiply-Accumulate Unit

This block is a two-lane SIMD multiply-accumulate datapath. Each of the two operand inputs carries two words. In each word one halfword is selected. The two selected halfwords of a lane are multiplied, and the product is added to or subtracted from that lane's word of an internal accumulator. The new value goes into the accumulator and also drives the result output, so a run of strobes forms a running dot product in each lane.

Five mode bits are sampled with each strobe:
- which halfword is taken;
- whether operands are signed;
- whether a signed product is read as a fraction (doubled);
- whether the lane result clamps or wraps;
- whether the product is added or subtracted.

Each saturating operation reports a per-lane overflow flag. A sticky copy of each flag gathers events until software-side logic clears it. Decode, register files and pipelining belong to the surrounding datapath.

Top module: `dual_mac_unit`

## Requirements
- R1: With `sel_odd`=0 each lane uses bits [2H-1:H] of its operand words (the upper halfword). With `sel_odd`=1 it uses bits [H-1:0]. The unselected halfword has no effect on any output.
- R2: Lane 1 (high) uses bits [4H-1:2H] of `op_a`, of `op_b` and of the accumulator. Lane 0 (low) uses bits [2H-1:0]. Lanes do not interact.
- R3: With `is_signed`=1, halfwords and the accumulator lane are two's-complement. With `is_signed`=0 they are unsigned, and `is_frac` has no effect.
- R4: With `is_signed`=1 and `is_frac`=1 the product is doubled (shifted left one bit) before accumulation. In modulo mode only its low 2H bits take part.
- R5: With signed, fractional and saturating mode, a product of two most-negative halfwords is replaced by the largest positive lane value, 2^(2H-1)-1. That lane's overflow flag is raised.
- R6: With `is_sub`=0 the product is added to the accumulator lane. With `is_sub`=1 it is subtracted from it.
- R7: With signed saturating mode, the exact sum or difference is clamped to [-2^(2H-1), 2^(2H-1)-1]. A clamp raises the lane's overflow flag.
- R8: With unsigned saturating mode, the difference or sum is formed as a signed exact value and clamped to [0, 2^(2H)-1]. An unsigned subtraction below zero gives 0. A clamp raises the lane's overflow flag.
- R9: With `is_sat`=0 each lane keeps the low 2H bits of the exact sum. `lane_ovf` keeps its previous value.
- R10: On each accepted saturating operation, `lane_ovf[1]` (high lane) and `lane_ovf[0]` (low lane) are loaded with the OR of that lane's product saturation and accumulation clamp.
- R11: An operation is accepted when `in_valid`=1. One cycle later `out_valid` is 1, and the new 4H-bit value appears on `result` and is the accumulator used by the next operation. Without a strobe, `result` holds and `out_valid` is 0.
- R12: `sticky_ovf[i]` is set by every overflow of lane i and is cleared only by `clr_sticky`. An overflow in the same cycle as a clear leaves the bit set.
- R13: Synchronous active-high `rst` clears the accumulator, `result`, `lane_ovf`, `sticky_ovf` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept one operation this cycle |
| sel_odd | input | 1 | 0: upper halfword, 1: lower halfword |
| is_signed | input | 1 | Signed operands and accumulator |
| is_frac | input | 1 | Fractional (doubled) signed product |
| is_sat | input | 1 | Saturate (1) or wrap (0) |
| is_sub | input | 1 | Subtract (1) or add (0) the product |
| clr_sticky | input | 1 | Clear sticky overflow bits |
| op_a | input | 4*HALF_W | Two words of the first operand |
| op_b | input | 4*HALF_W | Two words of the second operand |
| out_valid | output | 1 | Result updated in previous cycle |
| result | output | 4*HALF_W | Destination value, equal to the accumulator |
| lane_ovf | output | 2 | Per-lane overflow of last saturating operation |
| sticky_ovf | output | 2 | Per-lane accumulated overflow |

## Verification
The bench builds the unit with HALF_W=4, so each lane is an 8-bit word and each halfword has only 16 values. Every one of the 32 mode combinations is driven with every pair of halfwords in both lanes. The low lane gets a permuted pair, and the unselected halfwords hold the complement. The accumulator is carried across the whole sweep, so it drifts into both signed and unsigned clamps, into wrap-around and into the most-negative fractional product, instead of needing preset values. Clears are mixed in at intervals, some in cycles that also overflow.

// File: rtl/dual_mac_pkg.sv
package dual_mac_pkg;
  typedef struct packed {
    logic odd;
    logic sgn;
    logic frac;
    logic sat;
    logic sub;
  } mac_mode_t;
endpackage

// File: rtl/dual_mac_mul.sv
module dual_mac_mul
  import dual_mac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] word_a,
  input  logic [2*HALF_W-1:0] word_b,
  input  mac_mode_t           mode,
  output logic [2*HALF_W+1:0] prod,
  output logic                psat
);
  localparam int LW = 2 * HALF_W;
  localparam int EW = LW + 2;
  localparam logic [HALF_W-1:0] HMIN = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [EW-1:0]     PMAX = {3'b000, {(LW-1){1'b1}}};

  logic [HALF_W-1:0]        ha, hb;
  logic signed [HALF_W-1:0] sha, shb;
  logic signed [LW-1:0]     sprod;
  logic [LW-1:0]            uprod;

  // halfword pick (R1)
  assign ha  = mode.odd ? word_a[HALF_W-1:0] : word_a[LW-1:HALF_W];
  assign hb  = mode.odd ? word_b[HALF_W-1:0] : word_b[LW-1:HALF_W];
  assign sha = ha;
  assign shb = hb;

  always_comb begin
    sprod = sha * shb;
    uprod = ha * hb;
  end

  always_comb begin
    psat = 1'b0;
    if (mode.sgn) begin
      if (mode.frac) begin
        if (mode.sat && ha == HMIN && hb == HMIN) begin
          prod = PMAX;
          psat = 1'b1;
        end else begin
          prod = {sprod[LW-1], sprod, 1'b0};
        end
      end else begin
        prod = {{2{sprod[LW-1]}}, sprod};
      end
    end else begin
      prod = {2'b00, uprod};
    end
  end
endmodule

// File: rtl/dual_mac_lane.sv
module dual_mac_lane
  import dual_mac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] acc_in,
  input  logic [2*HALF_W+1:0] prod,
  input  logic                psat,
  input  mac_mode_t           mode,
  output logic [2*HALF_W-1:0] res,
  output logic                ovf
);
  localparam int LW = 2 * HALF_W;
  localparam int EW = LW + 2;
  localparam logic [EW-1:0] SMAX = {3'b000, {(LW-1){1'b1}}};
  localparam logic [EW-1:0] SMIN = {3'b111, {(LW-1){1'b0}}};

  logic [EW-1:0] acc_ext, sum;
  logic          s_hi, s_lo, u_hi, u_lo;

  always_comb begin
    acc_ext = mode.sgn ? {{2{acc_in[LW-1]}}, acc_in} : {2'b00, acc_in};
    sum     = mode.sub ? (acc_ext - prod) : (acc_ext + prod);
    s_hi    = $signed(sum) > $signed(SMAX);
    s_lo    = $signed(sum) < $signed(SMIN);
    u_lo    = sum[EW-1];
    u_hi    = !sum[EW-1] && sum[LW];
  end

  always_comb begin
    res = sum[LW-1:0];
    ovf = 1'b0;
    if (mode.sat) begin
      if (mode.sgn) begin
        if (s_hi) res = {1'b0, {(LW-1){1'b1}}};
        if (s_lo) res = {1'b1, {(LW-1){1'b0}}};
        ovf = psat | s_hi | s_lo;
      end else begin
        if (u_hi) res = {LW{1'b1}};
        if (u_lo) res = '0;
        ovf = psat | u_hi | u_lo;
      end
    end
  end
endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit
  import dual_mac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                sel_odd,
  input  logic                is_signed,
  input  logic                is_frac,
  input  logic                is_sat,
  input  logic                is_sub,
  input  logic                clr_sticky,
  input  logic [4*HALF_W-1:0] op_a,
  input  logic [4*HALF_W-1:0] op_b,
  output logic                out_valid,
  output logic [4*HALF_W-1:0] result,
  output logic [1:0]          lane_ovf,
  output logic [1:0]          sticky_ovf
);
  localparam int LW    = 2 * HALF_W;
  localparam int EW    = LW + 2;
  localparam int LANES = 2;

  mac_mode_t           mode;
  logic [4*HALF_W-1:0] acc_q, acc_d;
  logic [1:0]          ovf_d, ovf_q, sticky_q;
  logic                vld_q;

  assign mode = '{odd: sel_odd, sgn: is_signed, frac: is_frac, sat: is_sat, sub: is_sub};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [EW-1:0] prod;
    logic          psat;

    dual_mac_mul #(.HALF_W(HALF_W)) u_mul (
      .word_a (op_a[g*LW +: LW]),
      .word_b (op_b[g*LW +: LW]),
      .mode   (mode),
      .prod   (prod),
      .psat   (psat)
    );

    dual_mac_lane #(.HALF_W(HALF_W)) u_acc (
      .acc_in (acc_q[g*LW +: LW]),
      .prod   (prod),
      .psat   (psat),
      .mode   (mode),
      .res    (acc_d[g*LW +: LW]),
      .ovf    (ovf_d[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      ovf_q    <= '0;
      sticky_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) acc_q <= acc_d;
      if (in_valid && is_sat) ovf_q <= ovf_d;
      sticky_q <= (clr_sticky ? 2'b00 : sticky_q) | (in_valid ? ovf_d : 2'b00);
    end
  end

  assign out_valid  = vld_q;
  assign result     = acc_q;
  assign lane_ovf   = ovf_q;
  assign sticky_ovf = sticky_q;

  // R11
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && !out_valid));
  // R9
  mod_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_sat) |=> $stable(lane_ovf));
  // R12
  sticky_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_sat) |=> ((lane_ovf & ~sticky_ovf) == 2'b00));
  // R12
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_sticky && !in_valid) |=> (sticky_ovf == 2'b00));
endmodule

// File: tb/dual_mac_unit_test.sv
module dual_mac_unit_test;
  localparam int H  = 4;
  localparam int L  = 2 * H;
  localparam int W  = 4 * H;
  localparam int HM = (1 << H) - 1;
  localparam int LM = (1 << L) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, sel_odd = 1'b0, is_signed = 1'b0, is_frac = 1'b0;
  logic is_sat = 1'b0, is_sub = 1'b0, clr_sticky = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [W-1:0] result;
  logic [1:0] lane_ovf, sticky_ovf;

  int checks = 0, failures = 0;
  int exp_acc [2];
  bit [1:0] exp_ovf = 2'b00, exp_sticky = 2'b00;

  always #5 clk = ~clk;

  dual_mac_unit #(.HALF_W(H)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sel_odd(sel_odd),
    .is_signed(is_signed), .is_frac(is_frac), .is_sat(is_sat), .is_sub(is_sub),
    .clr_sticky(clr_sticky), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .result(result), .lane_ovf(lane_ovf), .sticky_ovf(sticky_ovf));

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int mk_word(int h, bit odd);
    int other = (~h) & HM;
    return odd ? ((other << H) | h) : ((h << H) | other);
  endfunction

  task automatic lane_model(input int ha, input int hb, input int acc,
                            input bit sgn, input bit frac, input bit sat,
                            input bit sub, output int res, output bit ovf);
    longint p, a, s;
    longint half  = 64'sd1 << (L - 1);
    longint full  = 64'sd1 << L;
    longint hhalf = 64'sd1 << (H - 1);
    bit psat = 0;
    ovf = 0;
    if (sgn) begin
      longint sa = (ha >= hhalf) ? ha - (hhalf * 2) : ha;
      longint sb = (hb >= hhalf) ? hb - (hhalf * 2) : hb;
      p = sa * sb;
      if (frac) begin
        if (sat && ha == hhalf && hb == hhalf) begin p = half - 1; psat = 1; end
        else p = p * 2;
      end
      a = (acc >= half) ? acc - full : acc;
    end else begin
      p = longint'(ha) * longint'(hb);
      a = acc;
    end
    s = sub ? a - p : a + p;
    if (sat) begin
      if (sgn) begin
        if (s > half - 1) begin s = half - 1; ovf = 1; end
        if (s < -half) begin s = -half; ovf = 1; end
      end else begin
        if (s > full - 1) begin s = full - 1; ovf = 1; end
        if (s < 0) begin s = 0; ovf = 1; end
      end
      ovf = ovf | psat;
    end
    res = int'(s & LM);
  endtask

  // drive one op at a negedge, check at the following negedge
  task automatic do_op(input int ah, input int bh, input int al, input int bl,
                       input bit [4:0] m, input bit clr);
    int r1, r0;
    bit o1, o0;
    bit odd = m[0], sgn = m[1], frac = m[2], sat = m[3], sub = m[4];
    in_valid = 1; sel_odd = odd; is_signed = sgn; is_frac = frac;
    is_sat = sat; is_sub = sub; clr_sticky = clr;
    op_a = W'((mk_word(ah, odd) << L) | mk_word(al, odd));
    op_b = W'((mk_word(bh, odd) << L) | mk_word(bl, odd));
    lane_model(ah, bh, exp_acc[1], sgn, frac, sat, sub, r1, o1);
    lane_model(al, bl, exp_acc[0], sgn, frac, sat, sub, r0, o0);
    exp_acc[1] = r1; exp_acc[0] = r0;
    if (sat) exp_ovf = {o1, o0};
    exp_sticky = (clr ? 2'b00 : exp_sticky) | {o1, o0};
    @(negedge clk);
    check(sat ? (sgn ? "R1 R2 R3 R4 R6 R7" : "R1 R2 R3 R6 R8") : "R1 R2 R3 R4 R6 R9",
          longint'(result), longint'((r1 << L) | r0));
    check(sat ? "R5 R10" : "R9", longint'(lane_ovf), longint'(exp_ovf));
    check("R12", longint'(sticky_ovf), longint'(exp_sticky));
    check("R11", longint'(out_valid), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n = 0;
    exp_acc[0] = 0; exp_acc[1] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R13 reset state
    check("R13", longint'(result), 0);
    check("R13", longint'({out_valid, lane_ovf, sticky_ovf}), 0);

    for (int m = 0; m < 32; m++) begin
      for (int a = 0; a <= HM; a++) begin
        for (int b = 0; b <= HM; b++) begin
          do_op(a, b, (a * 7 + 3) & HM, (b * 5 + 1) & HM, 5'(m), (n % 53) == 0);
          n++;
        end
      end
    end

    // R11 idle: other inputs toggled, nothing changes
    in_valid = 0; is_sub = ~is_sub; is_sat = 1; op_a = ~op_a; clr_sticky = 0;
    @(negedge clk);
    check("R11", longint'(result), longint'((exp_acc[1] << L) | exp_acc[0]));
    check("R11", longint'(out_valid), 0);
    check("R10", longint'(lane_ovf), longint'(exp_ovf));

    // R5 explicit: most-negative times most-negative, fractional saturating
    do_op(1 << (H - 1), 1 << (H - 1), 1 << (H - 1), 1 << (H - 1), 5'b01110, 0);
    check("R5", longint'(lane_ovf), 3);

    // R12 clear alone
    in_valid = 0; clr_sticky = 1;
    @(negedge clk);
    clr_sticky = 0;
    check("R12", longint'(sticky_ovf), 0);

    // R13 reset after activity
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R13", longint'(result), 0);
    check("R13", longint'({out_valid, lane_ovf, sticky_ovf}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule